// File: doc/BRIEF.md
# Link Interrupt Vector and Acknowledge Unit

This block gathers interrupt requests that arrive as single-cycle pulses from a peripheral link and keeps each one as a pending bit in a bank of 32-bit vector words. Each vector word has an enable word beside it. The block drives one summary interrupt line into an interrupt routing table. That line is high whenever any pending bit is also enabled.

Software services the line in two steps. It first reads a vector word. It then writes the same value back to that word, and every bit written as 1 is cleared. Only the bits software saw are cleared, so a request that arrives between the read and the write-back stays pending.

Source number `s` maps to vector word `s / 32`, bit `s % 32`. Sources 0 to 15 of a legacy interrupt controller therefore land on bits 0 to 15 of word 0. The default build has 8 words, which gives 256 sources.

Top module: `lirq_link_collector`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, every pending bit and every enable bit goes to 0, and `irq_out` is 0 in the cycle after the reset edge.
- R2: A pulse on `req_pulse[s]` sets pending bit `s % 32` of vector word `s / 32` at the next rising clock edge. This happens whatever the enable state of that bit.
- R3: A pending bit stays set until software clears it. Writing a 0 to a pending bit has no effect, and so do cycles with no write.
- R4: A write to byte offset `0x80 + 4*n` (vector word `n`) clears every pending bit of word `n` for which the written data bit is 1. The write takes effect at the clock edge that samples it.
- R5: When a request and a clear hit the same bit in the same cycle, the bit is left set.
- R6: A write to byte offset `0xA0 + 4*n` loads all 32 bits of enable word `n` from `wr_data`. For example, writing 0xFFFFFFFF to offset 0xA0 enables every bit of word 0.
- R7: `irq_out` is the OR, over all words, of (pending AND enable). It is low when every set pending bit is disabled.
- R8: A pending bit latched while disabled drives `irq_out` high in the cycle after its enable bit is written to 1.
- R9: `rd_data` combinationally returns the vector word or enable word selected by `addr`. Offsets outside 0x80 to 0xBF read as 0, and writes to them change no state.
- R10: Reading a vector word and writing the read value back clears exactly the bits that were read. A request that arrives between the read and the write-back survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse | input | NUM_WORDS*32 | One-cycle request pulse per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register being accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_out | output | 1 | Summary interrupt to the routing table |

## Verification
The bench builds the block with its default parameters: 8 words with vector base 0x80 and enable base 0xA0. With these values both banks fill the whole 0x80 to 0xBF window, so the last word at 0x9C and 0xBC can be reached. The offsets just outside the window, 0x7C and 0xC0, can also be reached to show they are ignored. Requests are spread over all 256 sources, so same-cycle request and clear collisions land on words other than word 0. Read and write-back sequences with a new request in between exercise the acknowledge ordering.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    parameter int WORD_W    = 32;
    parameter int MAX_WORDS = 8;
    parameter int IDX_W     = 3;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_VEC  = 2'd1,
        ACC_EN   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } acc_t;

    // New pending value: requests win over clears in the same cycle.
    function automatic logic [WORD_W-1:0] next_pending(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] clr,
        input logic [WORD_W-1:0] req
    );
        return (cur & ~clr) | req;
    endfunction
endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
    import lirq_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 8,
    parameter int VEC_BASE  = 'h80,
    parameter int EN_BASE   = 'hA0
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    localparam int SPAN = NUM_WORDS * 4;

    int a_int;

    always_comb begin
        a_int    = int'(addr);
        acc.kind = ACC_NONE;
        acc.idx  = '0;
        if (a_int >= VEC_BASE && a_int < VEC_BASE + SPAN) begin
            acc.kind = ACC_VEC;
            acc.idx  = IDX_W'((a_int - VEC_BASE) / 4);
        end else if (a_int >= EN_BASE && a_int < EN_BASE + SPAN) begin
            acc.kind = ACC_EN;
            acc.idx  = IDX_W'((a_int - EN_BASE) / 4);
        end
    end
endmodule

// File: rtl/lirq_word.sv
module lirq_word
    import lirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] req,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] pend_q,
    output logic [WORD_W-1:0] en_q
);
    logic [WORD_W-1:0] clr_mask;

    always_comb clr_mask = clr_we ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= next_pending(pend_q, clr_mask, req);
            if (en_we)
                en_q <= wr_data;
        end
    end
endmodule

// File: rtl/lirq_summary.sv
module lirq_summary
    import lirq_pkg::*;
#(
    parameter int NUM_WORDS = 8
) (
    input  logic [NUM_WORDS*WORD_W-1:0] pend,
    input  logic [NUM_WORDS*WORD_W-1:0] en,
    output logic                        irq
);
    logic [NUM_WORDS-1:0] word_hit;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_hit
        assign word_hit[g] = |(pend[g*WORD_W +: WORD_W] & en[g*WORD_W +: WORD_W]);
    end

    assign irq = |word_hit;
endmodule

// File: rtl/lirq_link_collector.sv
module lirq_link_collector
    import lirq_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 8,
    parameter int VEC_BASE  = 'h80,
    parameter int EN_BASE   = 'hA0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_WORDS*WORD_W-1:0] req_pulse,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        irq_out
);
    localparam int NSRC = NUM_WORDS * WORD_W;

    acc_t              acc;
    logic [WORD_W-1:0] pend_w [NUM_WORDS];
    logic [WORD_W-1:0] en_w   [NUM_WORDS];
    logic [NSRC-1:0]   pend_all;
    logic [NSRC-1:0]   en_all;

    lirq_decode #(
        .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W),
        .VEC_BASE(VEC_BASE),   .EN_BASE(EN_BASE)
    ) u_dec (
        .addr (addr),
        .acc  (acc)
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic clr_we_g;
        logic en_we_g;
        assign clr_we_g = wr_en && acc.kind == ACC_VEC && int'(acc.idx) == g;
        assign en_we_g  = wr_en && acc.kind == ACC_EN  && int'(acc.idx) == g;

        lirq_word u_word (
            .clk     (clk),
            .rst     (rst),
            .req     (req_pulse[g*WORD_W +: WORD_W]),
            .clr_we  (clr_we_g),
            .en_we   (en_we_g),
            .wr_data (wr_data),
            .pend_q  (pend_w[g]),
            .en_q    (en_w[g])
        );

        assign pend_all[g*WORD_W +: WORD_W] = pend_w[g];
        assign en_all[g*WORD_W +: WORD_W]   = en_w[g];
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(acc.idx) == w) begin
                if (acc.kind == ACC_VEC) rd_data = pend_w[w];
                if (acc.kind == ACC_EN)  rd_data = en_w[w];
            end
        end
    end

    lirq_summary #(.NUM_WORDS(NUM_WORDS)) u_sum (
        .pend (pend_all),
        .en   (en_all),
        .irq  (irq_out)
    );
endmodule

// File: rtl/lirq_link_checker.sv
module lirq_link_checker #(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 8,
    parameter int EN_BASE   = 'hA0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_WORDS*32-1:0]  req_pulse,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [31:0]              wr_data,
    input logic [NUM_WORDS*32-1:0]  pend,
    input logic [NUM_WORDS*32-1:0]  en,
    input logic                     irq_out
);
    logic en_hit;
    int   last_idx;

    assign en_hit = wr_en && int'(addr) >= EN_BASE && int'(addr) < EN_BASE + NUM_WORDS*4;

    always_ff @(posedge clk) begin
        if (rst) last_idx <= 0;
        else if (en_hit) last_idx <= (int'(addr) - EN_BASE) / 4;
    end

    // R1: reset empties both banks
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pend == '0 && en == '0));

    // R2: a request is always captured
    assert_req_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (req_pulse != '0) |=> ((pend & $past(req_pulse)) == $past(req_pulse)));

    // R3: without a write nothing is cleared
    assert_hold_pending_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((pend & $past(pend)) == $past(pend)));

    // R6: enable word takes write data
    assert_enable_load_R6: assert property (@(posedge clk) disable iff (rst)
        en_hit |=> (en[last_idx*32 +: 32] == $past(wr_data)));

    // R7: summary follows pending and enable state
    assert_summary_R7: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(pend & en));
endmodule

bind lirq_link_collector lirq_link_checker #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .EN_BASE(EN_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_pulse (req_pulse),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .pend      (pend_all),
    .en        (en_all),
    .irq_out   (irq_out)
);

// File: tb/lirq_link_collector_test.sv
`timescale 1ns/1ps
module lirq_link_collector_test;
    localparam int NW = 8;
    localparam int NS = NW * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] req_pulse = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_pend [NW];
    logic [31:0] m_en   [NW];

    always #2.5 clk = ~clk;

    lirq_link_collector uut (
        .clk(clk), .rst(rst), .req_pulse(req_pulse), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a >= 8'h80 && a < 8'hA0) return m_pend[(a - 8'h80) >> 2];
        if (a >= 8'hA0 && a < 8'hC0) return m_en[(a - 8'hA0) >> 2];
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int w = 0; w < NW; w++) r |= |(m_pend[w] & m_en[w]);
        return r;
    endfunction

    task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [NS-1:0] r, input logic we,
                        input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_pulse = r; wr_en = we; addr = a; wr_data = d;
        @(posedge clk);
        for (int w = 0; w < NW; w++) begin
            logic [31:0] clr = 32'h0;
            if (we && a == 8'(8'h80 + 4*w)) clr = d;
            m_pend[w] = (m_pend[w] & ~clr) | r[w*32 +: 32];
            if (we && a == 8'(8'hA0 + 4*w)) m_en[w] = d;
        end
    endtask

    task automatic rd_check(input logic [7:0] a, input string tag);
        @(negedge clk);
        req_pulse = '0; wr_en = 1'b0; addr = a;
        #1 compare(rd_data, exp_rd(a), tag);
    endtask

    task automatic irq_check(input string tag);
        @(negedge clk);
        req_pulse = '0; wr_en = 1'b0;
        #1 compare({31'h0, irq_out}, {31'h0, exp_irq()}, tag);
    endtask

    function automatic logic [NS-1:0] one(input int s);
        logic [NS-1:0] v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seen;
        void'($urandom(32'd20240611));
        for (int w = 0; w < NW; w++) begin m_pend[w] = '0; m_en[w] = '0; end

        // R1: reset, with a request pending on the input during reset
        req_pulse = one(3);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; req_pulse = '0;
        rd_check(8'h80, "R1 vec0 after reset");
        rd_check(8'hBC, "R1 en7 after reset");
        irq_check("R1 irq after reset");

        // R2: capture while disabled
        step(one(5) | one(200), 1'b0, 8'h00, 32'h0);
        rd_check(8'h80, "R2 word0 bit5");
        rd_check(8'h98, "R2 word6 bit8");
        irq_check("R7 disabled pending keeps irq low");

        // R3: writing zeros does not clear
        step('0, 1'b1, 8'h80, 32'h0);
        step('0, 1'b0, 8'h00, 32'h0);
        rd_check(8'h80, "R3 zero write keeps bit");

        // R8 / R6: enable all of word 0
        step('0, 1'b1, 8'hA0, 32'hFFFF_FFFF);
        irq_check("R8 irq after enable");
        rd_check(8'hA0, "R6 enable word0 readback");

        // R10: read, new request arrives, write back
        rd_check(8'h80, "R10 read before ack");
        seen = rd_data;
        step(one(9), 1'b0, 8'h00, 32'h0);
        step('0, 1'b1, 8'h80, seen);
        rd_check(8'h80, "R10 later request survives ack");

        // R5: request and clear collide on word1 bit3
        step(one(35), 1'b0, 8'h00, 32'h0);
        step(one(35), 1'b1, 8'h84, 32'h0000_0008);
        rd_check(8'h84, "R5 request wins over clear");

        // R4: clear word6 bit8
        step('0, 1'b1, 8'h98, 32'h0000_0100);
        rd_check(8'h98, "R4 clear word6");

        // R9: out-of-window offsets
        step('0, 1'b1, 8'hC0, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h7C, 32'hFFFF_FFFF);
        rd_check(8'hC0, "R9 read 0xC0");
        rd_check(8'h7C, "R9 read 0x7C");
        rd_check(8'h80, "R9 vec0 unchanged by stray write");
        rd_check(8'hBC, "R9 en7 unchanged by stray write");

        // R6: last enable word
        step('0, 1'b1, 8'hBC, 32'h8000_0001);
        rd_check(8'hBC, "R6 enable word7");
        step(one(255), 1'b0, 8'h00, 32'h0);
        irq_check("R7 irq from word7");

        // Random phase
        for (int i = 0; i < 600; i++) begin
            logic [NS-1:0] r = '0;
            logic          we;
            logic [7:0]    a;
            logic [31:0]   d;
            for (int k = 0; k < 3; k++)
                if ($urandom % 3 == 0) r[$urandom % NS] = 1'b1;
            we = ($urandom % 2) == 1;
            case ($urandom % 8)
                0:       a = 8'hC0;
                1:       a = 8'h7C;
                2, 3, 4: a = 8'(8'h80 + 4 * ($urandom % NW));
                default: a = 8'(8'hA0 + 4 * ($urandom % NW));
            endcase
            d = ($urandom % 4 == 0) ? exp_rd(a) : $urandom & $urandom;
            step(r, we, a, d);
            if (i % 7 == 0) irq_check("R7 random irq");
            if (i % 60 == 0)
                for (int w = 0; w < 16; w++)
                    rd_check(8'(8'h80 + 4 * w), "R2 R4 R5 R6 random readback");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule